// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block sits beside one processor's data cache and keeps the single reservation that a load-linked / store-conditional pair needs. A load-linked request captures the cache-block number of its address and arms a reservation bit. The bit is dropped by anything that could let another agent's write slip in between the pair. That includes a snooped invalidation of the same block, a local eviction of that block, or a context switch. A store-conditional is granted only while the bit is armed and the store falls in the reserved block.

The answer to every store-conditional comes back one clock later as a single-cycle valid pulse with a pass/fail bit. In that same cycle a cache write enable is raised only for a pass. A failing store-conditional therefore never reaches the cache write port, so it can never cause an ownership request or an invalidation on the bus. Block size and address width are parameters. By default addresses are 32 bits and a block is 64 bytes, so the block number is address bits [31:6].

Top module: `llsc_resv_unit`

## Requirements
- R1: After reset no reservation exists and all three outputs are 0; a store-conditional issued before any load-linked fails.
- R2: After a load-linked, a store-conditional to any byte address in the same 64-byte block (address bits [31:6] equal) passes.
- R3: A store-conditional whose block number differs from the reserved one fails.
- R4: A valid snoop invalidation to the reserved block drops the reservation; one to another block leaves it armed.
- R5: A local eviction of the reserved block drops the reservation; an eviction of another block leaves it armed.
- R6: A context-switch pulse drops the reservation whatever the addresses.
- R7: Every store-conditional, pass or fail, drops the reservation, so a second store-conditional without a new load-linked fails.
- R8: A new load-linked replaces the previous reservation; only its block can then pass.
- R9: When a store-conditional arrives in the same cycle as a snoop invalidation or eviction of the reserved block, or a context switch, the store-conditional fails.
- R10: Each store-conditional yields exactly one `sc_done` pulse in the following cycle, with `sc_pass` 1 for pass and 0 for fail. `cache_wr_en` is high only in a cycle with a passing result. No pulse appears otherwise.
- R11: When load-linked and store-conditional are requested in the same cycle, the store-conditional is judged against the existing reservation and the load-linked is ignored.
- R12: A load-linked that coincides with an invalidation or eviction of its own block, or with a context switch, leaves no reservation. A coincident invalidation of another block does not prevent the reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_req | input | 1 | Load-linked request this cycle |
| sc_req | input | 1 | Store-conditional request this cycle |
| req_addr | input | ADDR_W | Byte address of the load-linked or store-conditional |
| snoop_inv_valid | input | 1 | A bus invalidation is being snooped |
| snoop_inv_addr | input | ADDR_W | Address of the snooped invalidation |
| evict_valid | input | 1 | The local cache is replacing a block |
| evict_addr | input | ADDR_W | Address of the block being replaced |
| ctx_switch | input | 1 | Context-switch pulse |
| sc_done | output | 1 | One-cycle result valid for a store-conditional |
| sc_pass | output | 1 | 1 = store-conditional passed, 0 = failed (valid with sc_done) |
| cache_wr_en | output | 1 | Write enable to the cache for a passing store-conditional |

## Verification
The bound checker watches, on every cycle, the result handshake: one pulse per store-conditional and none otherwise. It also checks that the cache write never occurs without a pass. On every cycle it further confirms that a store-conditional fails when it is back-to-back with another one, when it comes before any load-linked, or when it collides with a context switch or with an invalidation of its own block. Whether an earlier, non-coincident snoop, eviction or context switch really dropped the right reservation depends on history that no single-cycle property sees. The bench's scenarios show this through the later store-conditional outcome. The same holds for block-granular matching, replacement by a newer load-linked, and the load-linked collision cases.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Default geometry of the reservation
    localparam int DEF_ADDR_W      = 32;
    localparam int DEF_BLOCK_BYTES = 64;

    // Lanes of the compare against the stored reservation
    localparam int L_REQ   = 0;
    localparam int L_SNOOP = 1;
    localparam int L_EVICT = 2;
    localparam int N_OLD_LANES = 3;

    // Lanes of the compare against an incoming load-linked block
    localparam int K_SNOOP = 0;
    localparam int K_EVICT = 1;
    localparam int N_NEW_LANES = 2;

    // Registered answer to a store-conditional
    typedef struct packed {
        logic done;
        logic pass;
        logic wr;
    } sc_out_t;

    function automatic int blk_off_bits(input int block_bytes);
        return $clog2(block_bytes);
    endfunction

endpackage

// File: rtl/llsc_blk_cmp.sv
module llsc_blk_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int N      = 2
) (
    input  logic [ADDR_W-1:0]       addr [N],
    input  logic [N-1:0]            vld,
    input  logic [ADDR_W-OFF_W-1:0] ref_tag,
    output logic [N-1:0]            hit
);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] ref_ext;
    assign ref_ext = ADDR_W'(ref_tag);

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [ADDR_W-1:0] blk_no;
        assign blk_no = addr[i] >> OFF_W;
        assign hit[i] = vld[i] && (blk_no == ref_ext);
    end

    if (TAG_W < 1) begin : g_bad
        initial $display("llsc_blk_cmp: block larger than address space");
    end
endmodule

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             load_armed,
    input  logic [TAG_W-1:0] load_tag,
    input  logic             drop,
    output logic             armed,
    output logic [TAG_W-1:0] tag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            tag   <= '0;
        end else if (load) begin
            armed <= load_armed;
            tag   <= load_tag;
        end else if (drop) begin
            armed <= 1'b0;
        end
    end
endmodule

// File: rtl/llsc_sc_result.sv
module llsc_sc_result
    import llsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sc_req,
    input  logic    grant,
    output sc_out_t res
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else begin
            res.done <= sc_req;
            res.pass <= sc_req && grant;
            res.wr   <= sc_req && grant;
        end
    end
endmodule

// File: rtl/llsc_resv_unit.sv
module llsc_resv_unit
    import llsc_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int BLOCK_BYTES = DEF_BLOCK_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_req,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              snoop_inv_valid,
    input  logic [ADDR_W-1:0] snoop_inv_addr,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              ctx_switch,
    output logic              sc_done,
    output logic              sc_pass,
    output logic              cache_wr_en
);
    localparam int OFF_W = blk_off_bits(BLOCK_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic             resv_armed;
    logic [TAG_W-1:0] resv_tag;
    logic [TAG_W-1:0] req_tag;

    // Compare incoming addresses with the stored reservation
    logic [ADDR_W-1:0]      old_addr [N_OLD_LANES];
    logic [N_OLD_LANES-1:0] old_vld;
    logic [N_OLD_LANES-1:0] old_hit;

    assign old_addr[L_REQ]   = req_addr;
    assign old_addr[L_SNOOP] = snoop_inv_addr;
    assign old_addr[L_EVICT] = evict_addr;
    assign old_vld[L_REQ]    = sc_req;
    assign old_vld[L_SNOOP]  = snoop_inv_valid;
    assign old_vld[L_EVICT]  = evict_valid;

    llsc_blk_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .N(N_OLD_LANES)) u_cmp_old (
        .addr    (old_addr),
        .vld     (old_vld),
        .ref_tag (resv_tag),
        .hit     (old_hit)
    );

    // Compare kill sources with the block a load-linked is about to reserve
    logic [ADDR_W-1:0]      new_addr [N_NEW_LANES];
    logic [N_NEW_LANES-1:0] new_vld;
    logic [N_NEW_LANES-1:0] new_hit;

    assign req_tag           = req_addr[ADDR_W-1:OFF_W];
    assign new_addr[K_SNOOP] = snoop_inv_addr;
    assign new_addr[K_EVICT] = evict_addr;
    assign new_vld[K_SNOOP]  = snoop_inv_valid;
    assign new_vld[K_EVICT]  = evict_valid;

    llsc_blk_cmp #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .N(N_NEW_LANES)) u_cmp_new (
        .addr    (new_addr),
        .vld     (new_vld),
        .ref_tag (req_tag),
        .hit     (new_hit)
    );

    // Reservation control
    logic kill_old, kill_new, take_ll, grant, drop;

    always_comb begin
        kill_old = old_hit[L_SNOOP] | old_hit[L_EVICT] | ctx_switch;
        kill_new = (|new_hit) | ctx_switch;
        take_ll  = ll_req & ~sc_req;
        grant    = sc_req & resv_armed & old_hit[L_REQ] & ~kill_old;
        drop     = sc_req | kill_old;
    end

    llsc_resv_reg #(.TAG_W(TAG_W)) u_resv (
        .clk        (clk),
        .rst        (rst),
        .load       (take_ll),
        .load_armed (~kill_new),
        .load_tag   (req_tag),
        .drop       (drop),
        .armed      (resv_armed),
        .tag        (resv_tag)
    );

    sc_out_t res;

    llsc_sc_result u_res (
        .clk    (clk),
        .rst    (rst),
        .sc_req (sc_req),
        .grant  (grant),
        .res    (res)
    );

    assign sc_done     = res.done;
    assign sc_pass     = res.pass;
    assign cache_wr_en = res.wr;
endmodule

// File: rtl/llsc_resv_chk.sv
module llsc_resv_chk #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              ll_req,
    input logic              sc_req,
    input logic [ADDR_W-1:0] req_addr,
    input logic              snoop_inv_valid,
    input logic [ADDR_W-1:0] snoop_inv_addr,
    input logic              ctx_switch,
    input logic              sc_done,
    input logic              sc_pass,
    input logic              cache_wr_en
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);

    logic prev_sc;
    logic seen_ll;
    logic inv_same_blk;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sc <= 1'b0;
            seen_ll <= 1'b0;
        end else begin
            prev_sc <= sc_req;
            if (ll_req) seen_ll <= 1'b1;
        end
    end

    assign inv_same_blk = snoop_inv_valid &&
                          ((snoop_inv_addr >> OFF_W) == (req_addr >> OFF_W));

    AST_DONE_AFTER_SC: assert property (@(posedge clk) disable iff (rst)
        sc_req |=> sc_done);                                  // R10
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
        !sc_req |=> !sc_done);                                // R10
    AST_WR_ONLY_ON_PASS: assert property (@(posedge clk) disable iff (rst)
        cache_wr_en |-> (sc_done && sc_pass));                // R10
    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        sc_pass |-> sc_done);                                 // R10
    AST_BACK_TO_BACK_FAIL: assert property (@(posedge clk) disable iff (rst)
        (sc_req && prev_sc) |=> !sc_pass);                    // R7
    AST_NO_LL_NO_PASS: assert property (@(posedge clk) disable iff (rst)
        (sc_req && !seen_ll) |=> !sc_pass);                   // R1
    AST_CTX_COLLIDE_FAIL: assert property (@(posedge clk) disable iff (rst)
        (sc_req && ctx_switch) |=> !sc_pass);                 // R9
    AST_INV_COLLIDE_FAIL: assert property (@(posedge clk) disable iff (rst)
        (sc_req && inv_same_blk) |=> !sc_pass);               // R9
endmodule

bind llsc_resv_unit llsc_resv_chk #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (.*);

// File: tb/tb_llsc_resv_unit.sv
module tb_llsc_resv_unit;
    localparam int AW = 32;
    localparam logic [AW-1:0] A  = 32'h0000_1000;
    localparam logic [AW-1:0] A2 = 32'h0000_103C;  // same block as A
    localparam logic [AW-1:0] A3 = 32'h0000_1008;  // same block as A
    localparam logic [AW-1:0] B  = 32'h0000_2040;
    localparam logic [AW-1:0] Z  = 32'h0;

    typedef struct packed {
        logic          ll;
        logic          sc;
        logic [AW-1:0] addr;
        logic          iv;
        logic [AW-1:0] ia;
        logic          ev;
        logic [AW-1:0] ea;
        logic          ctx;
        logic          done;
        logic          pass;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 35;
    // ll sc addr iv ia ev ea ctx | done pass req
    localparam vec_t VT [NV] = '{
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd1 },  // R1: no LL yet
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b1,A2,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b1, 8'd2 },  // R2: other offset
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd7 },  // R7: second SC
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b1,B ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd3 },  // R3: wrong block
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b0,Z ,1'b1,B ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd4 },  // R4: other-block inval
        '{1'b0,1'b0,Z ,1'b0,Z ,1'b1,B ,1'b0, 1'b0,1'b0, 8'd5 },  // R5: other-block evict
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b1, 8'd4 },  // R4 R5: still armed
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b0,Z ,1'b1,A3,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd4 },
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd4 },  // R4: inval killed it
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b0,Z ,1'b0,Z ,1'b1,A2,1'b0, 1'b0,1'b0, 8'd5 },
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd5 },  // R5: evict killed it
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b0,Z ,1'b0,Z ,1'b0,Z ,1'b1, 1'b0,1'b0, 8'd6 },
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd6 },  // R6: ctx killed it
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b1,1'b0,B ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd8 },
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd8 },  // R8: A replaced by B
        '{1'b1,1'b0,B ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b1,B ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b1, 8'd8 },  // R8: B passes
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b1,A ,1'b1,A2,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd9 },  // R9: inval collides
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b1, 1'b1,1'b0, 8'd9 },  // R9: ctx collides
        '{1'b1,1'b0,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd10},
        '{1'b1,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b1, 8'd11},  // R11: SC wins
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd11},  // R11: LL was ignored
        '{1'b1,1'b0,A ,1'b1,A3,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd12},
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b0, 8'd12},  // R12: no reservation
        '{1'b1,1'b0,A ,1'b1,B ,1'b0,Z ,1'b0, 1'b0,1'b0, 8'd12},
        '{1'b0,1'b1,A ,1'b0,Z ,1'b0,Z ,1'b0, 1'b1,1'b1, 8'd12}   // R12: armed
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ll_req = 1'b0, sc_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          snoop_inv_valid = 1'b0;
    logic [AW-1:0] snoop_inv_addr = '0;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic          ctx_switch = 1'b0;
    logic          sc_done, sc_pass, cache_wr_en;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    llsc_resv_unit dut (
        .clk             (clk),
        .rst             (rst),
        .ll_req          (ll_req),
        .sc_req          (sc_req),
        .req_addr        (req_addr),
        .snoop_inv_valid (snoop_inv_valid),
        .snoop_inv_addr  (snoop_inv_addr),
        .evict_valid     (evict_valid),
        .evict_addr      (evict_addr),
        .ctx_switch      (ctx_switch),
        .sc_done         (sc_done),
        .sc_pass         (sc_pass),
        .cache_wr_en     (cache_wr_en)
    );

    task automatic check(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ll_req = 1'b0; sc_req = 1'b0; req_addr = '0;
        snoop_inv_valid = 1'b0; snoop_inv_addr = '0;
        evict_valid = 1'b0; evict_addr = '0; ctx_switch = 1'b0;
    endtask

    task automatic check_outs(input string tag, input logic d, input logic p);
        check({tag, " sc_done"}, sc_done, d);
        check({tag, " sc_pass"}, sc_pass, p);
        check({tag, " cache_wr_en"}, cache_wr_en, d & p);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        check_outs("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_outs("R1 after reset", 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            ll_req = VT[i].ll; sc_req = VT[i].sc; req_addr = VT[i].addr;
            snoop_inv_valid = VT[i].iv; snoop_inv_addr = VT[i].ia;
            evict_valid = VT[i].ev; evict_addr = VT[i].ea;
            ctx_switch = VT[i].ctx;
            @(negedge clk);
            check_outs($sformatf("R%0d row%0d", VT[i].req, i), VT[i].done, VT[i].pass);
            if (VT[i].sc == 1'b0)
                check($sformatf("R10 row%0d no pulse", i), sc_done, 1'b0);
        end

        // R10: pulse lasts one cycle only
        idle_inputs();
        @(negedge clk);
        check_outs("R10 idle after result", 1'b0, 1'b0);

        // R1: reset mid-run wipes the reservation
        ll_req = 1'b1; req_addr = A;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        check_outs("R1 reset pulse", 1'b0, 1'b0);
        rst = 1'b0;
        sc_req = 1'b1; req_addr = A;
        @(negedge clk);
        check_outs("R1 SC after reset", 1'b1, 1'b0);
        idle_inputs();
        @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule